// File: doc/BRIEF.md
# Per-Character Blink Attribute Unit

This unit holds one blink attribute bit for each of eight character positions of a small dot-matrix display and turns those bits into a per-position blank mask. The display driver uses the mask to suppress a character's dots. A slow phase generator divides the display clock by 28,672 and alternates between a visible half and a blanked half, each 14,336 clocks long. A character is blanked only while three things hold at once: the global enable bit taken from the control word is high, its own attribute bit is 1, and the phase generator is in its blanked half.

The host bus reaches the attribute bits only while the dedicated attribute-select input is high. That select overrides normal address decoding. In this mode the low three address bits pick the position and the upper two are ignored. A write stores data bit 0 and ignores data bits 7..1. A read returns the addressed bit in data bit 0.

The bus decoder resolves each cycle into one of three operations: `BUS_IDLE`, `BUS_WRITE` or `BUS_READ`. Write wins when both strobes are high. The phase generator is a two-state machine:
- `PH_SHOW` moves to `PH_BLANK` when the counter reaches 14,335.
- `PH_BLANK` returns to `PH_SHOW` when the counter wraps from 28,671 to 0.

Top module: `char_blink_unit`

## Requirements
- R1: While reset is applied, and in the first cycle after it is released, every attribute bit, the divider counter and the phase are cleared. As a result `blank_mask` is 0 and every attribute read returns 0.
- R2: On a clock edge with `attr_sel`=1 and `bus_wr`=1, `wdata[0]` is stored in the attribute of position `addr[2:0]`. `addr[4:3]` have no effect on which position is written.
- R3: `wdata[7:1]` never affect the stored attribute.
- R4: With `attr_sel`=1 and `bus_rd`=1 (and `bus_wr`=0), `rdata` is combinationally `{7'b0, attribute[addr[2:0]]}`. `addr[4:3]` are ignored. In every other case `rdata` is 0.
- R5: A write strobe with `attr_sel`=0 changes no attribute bit.
- R6: The phase generator counts clock edges since reset modulo 28,672. The phase is blanked exactly when that count lies in 14,336..28,671. The first blanked cycle is therefore the 14,336th edge after reset release, and each half lasts 14,336 cycles.
- R7: `blank_mask[i]` = `blink_en` AND attribute[i] AND phase. When `blink_en` is 0 the whole mask is 0, and positions with a cleared attribute are never blanked.
- R8: Positions are independent: a write to one position leaves the other seven unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Active-low synchronous reset |
| attr_sel | input | 1 | Selects the attribute store for bus access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe, combinational read |
| addr | input | 5 | Bus address; bits 2..0 pick the position |
| wdata | input | 8 | Write data; only bit 0 is used |
| rdata | output | 8 | Read data; the attribute appears in bit 0 |
| blink_en | input | 1 | Global blink enable from the control word |
| blank_mask | output | 8 | Per-position blank request, bit i for position i |

## Verification
The assertions assume that reset is held low across the first clock edge. They also assume that the bus strobes and address are stable around each rising edge, so each cycle decodes to exactly one operation. The bench meets both assumptions by holding reset for several cycles and by changing every input only on the falling edge. It never relies on a simultaneous read and write, apart from the documented write priority. The phase timing is checked against an edge counter that the bench keeps from reset release, with no reference to the divider's internals.

// File: rtl/cblink_pkg.sv
package cblink_pkg;
    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_WRITE = 2'd1,
        BUS_READ  = 2'd2
    } bus_op_e;

    typedef enum logic {
        PH_SHOW  = 1'b0,
        PH_BLANK = 1'b1
    } phase_e;
endpackage

// File: rtl/cblink_bus_decode.sv
module cblink_bus_decode
    import cblink_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int POS_W  = 3
) (
    input  logic              attr_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] addr,
    output bus_op_e           op,
    output logic [POS_W-1:0]  pos
);
    // Upper address bits are ignored while the attribute store is selected.
    assign pos = addr[POS_W-1:0];

    always_comb begin
        op = BUS_IDLE;
        if (attr_sel) begin
            unique case ({bus_wr, bus_rd})
                2'b10, 2'b11: op = BUS_WRITE;
                2'b01:        op = BUS_READ;
                default:      op = BUS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cblink_attr_store.sv
module cblink_attr_store
    import cblink_pkg::*;
#(
    parameter int NPOS   = 8,
    parameter int DATA_W = 8,
    localparam int POS_W = $clog2(NPOS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_op_e           op,
    input  logic [POS_W-1:0]  pos,
    input  logic [DATA_W-1:0] wdata,
    output logic [NPOS-1:0]   attrs,
    output logic [DATA_W-1:0] rdata
);
    genvar gi;
    generate
        for (gi = 0; gi < NPOS; gi++) begin : g_bit
            always_ff @(posedge clk) begin
                if (!rst_n)
                    attrs[gi] <= 1'b0;
                else if (op == BUS_WRITE && pos == POS_W'(gi))
                    attrs[gi] <= wdata[0];
            end
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (op == BUS_READ)
            rdata[0] = attrs[pos];
    end

    assert_write_stores_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == BUS_WRITE) |=> (attrs[$past(pos)] == $past(wdata[0])));

    assert_no_write_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op != BUS_WRITE) |=> $stable(attrs));

    assert_single_bit_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == BUS_WRITE) |=> ($countones(attrs ^ $past(attrs)) <= 1));
endmodule

// File: rtl/cblink_phase_gen.sv
module cblink_phase_gen
    import cblink_pkg::*;
#(
    parameter int PERIOD = 28672,
    localparam int HALF  = PERIOD / 2,
    localparam int CNT_W = $clog2(PERIOD)
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    logic [CNT_W-1:0] cnt_q;
    phase_e           state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == CNT_W'(PERIOD - 1))
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_SHOW:  if (cnt_q == CNT_W'(HALF - 1))   state_d = PH_BLANK;
            PH_BLANK: if (cnt_q == CNT_W'(PERIOD - 1)) state_d = PH_SHOW;
            default:  state_d = PH_SHOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_SHOW;
        else        state_q <= state_d;
    end

    always_comb phase = (state_q == PH_BLANK);

    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(PERIOD));

    assert_enter_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_SHOW && cnt_q == CNT_W'(HALF - 1)) |=> (state_q == PH_BLANK));

    assert_wrap_show_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_W'(PERIOD - 1)) |=> (cnt_q == '0 && state_q == PH_SHOW));
endmodule

// File: rtl/char_blink_unit.sv
module char_blink_unit
    import cblink_pkg::*;
#(
    parameter int NPOS   = 8,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int PERIOD = 28672,
    localparam int POS_W = $clog2(NPOS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              attr_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              blink_en,
    output logic [NPOS-1:0]   blank_mask
);
    bus_op_e          op;
    logic [POS_W-1:0] pos;
    logic [NPOS-1:0]  attrs;
    logic             phase;

    cblink_bus_decode #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u_decode (
        .attr_sel(attr_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .addr(addr), .op(op), .pos(pos)
    );

    cblink_attr_store #(.NPOS(NPOS), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .op(op), .pos(pos),
        .wdata(wdata), .attrs(attrs), .rdata(rdata)
    );

    cblink_phase_gen #(.PERIOD(PERIOD)) u_phase (
        .clk(clk), .rst_n(rst_n), .phase(phase)
    );

    always_comb blank_mask = (blink_en && phase) ? attrs : '0;

    assert_mask_off_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !blink_en |-> (blank_mask == '0));

    assert_mask_within_attrs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((blank_mask & ~attrs) == '0));

    assert_rdata_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(attr_sel && bus_rd) |-> (rdata == '0));
endmodule

// File: tb/char_blink_unit_test.sv
module char_blink_unit_test;
    localparam int PERIOD = 28672;
    localparam int HALF   = PERIOD / 2;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       attr_sel = 0, bus_wr = 0, bus_rd = 0, blink_en = 0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] blank_mask;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    char_blink_unit uut (
        .clk(clk), .rst_n(rst_n), .attr_sel(attr_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .addr(addr), .wdata(wdata), .rdata(rdata),
        .blink_en(blink_en), .blank_mask(blank_mask)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        attr_sel = sel; bus_wr = 1; addr = a; wdata = d;
        @(negedge clk);
        attr_sel = 0; bus_wr = 0; addr = '0; wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        attr_sel = 1; bus_rd = 1; addr = a;
        #1 d = rdata;
        attr_sel = 0; bus_rd = 0; addr = '0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 mask after reset", blank_mask, 0);
        for (int p = 0; p < 8; p++) begin
            rd(5'(p), d);
            check("R1 attr read after reset", d, 0);
        end
    endtask

    task automatic t_write_read();
        logic [7:0] d;
        wr(1, 5'b11_010, 8'h01);              // upper address bits set
        rd(5'b00_010, d);
        check("R2 write pos2 ignoring addr[4:3]", d, 8'h01);
        rd(5'b01_010, d);
        check("R4 read ignores addr[4:3]", d, 8'h01);
        wr(1, 5'd5, 8'hFE);                   // bit0 clear, others set
        rd(5'd5, d);
        check("R3 upper data bits ignored", d, 8'h00);
        wr(1, 5'd5, 8'h01);
        wr(1, 5'd5, 8'h00);
        rd(5'd5, d);
        check("R2 write 0 clears", d, 8'h00);
        @(negedge clk);
        bus_rd = 1; addr = 5'd2; attr_sel = 0;
        #1 check("R4 rdata zero without select", rdata, 0);
        bus_rd = 0; addr = '0;
    endtask

    task automatic t_no_select();
        logic [7:0] d;
        wr(0, 5'd4, 8'h01);
        rd(5'd4, d);
        check("R5 write without select ignored", d, 0);
    endtask

    task automatic t_independent();
        logic [7:0] d;
        wr(1, 5'd0, 8'h01);
        wr(1, 5'd7, 8'h01);
        wr(1, 5'd7, 8'h00);
        rd(5'd0, d);
        check("R8 pos0 kept", d, 1);
        rd(5'd2, d);
        check("R8 pos2 kept", d, 1);
        rd(5'd7, d);
        check("R8 pos7 cleared", d, 0);
    endtask

    task automatic t_phase();
        int t0;
        blink_en = 1;
        @(negedge clk);
        check("R6 mask idle in visible half", blank_mask, 0);
        while (blank_mask == 0 && cyc < 3 * PERIOD) @(negedge clk);
        check("R6 first blank edge", cyc, HALF);
        check("R7 mask = attrs while blanked", blank_mask, 8'h05);
        blink_en = 0;
        #1 check("R7 enable low clears mask", blank_mask, 0);
        blink_en = 1;
        #1 check("R7 enable restored", blank_mask, 8'h05);
        t0 = cyc;
        while (blank_mask != 0 && cyc < 3 * PERIOD) @(negedge clk);
        check("R6 blank half length", cyc - t0, HALF);
        check("R6 wrap edge", cyc, PERIOD);
        while (blank_mask == 0 && cyc < 3 * PERIOD) @(negedge clk);
        check("R6 second blank edge", cyc, PERIOD + HALF);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_no_select();
        t_independent();
        t_phase();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule